// File: doc/BRIEF.md
# Strobed handshake parallel port

This block is one 8-bit parallel channel between a CPU and a slow peripheral, paced by a two-wire strobed handshake that sits on fixed Port C bit positions. A configuration bit picks the direction.

In the input direction the peripheral pulls its strobe low. The block then captures the byte on the peripheral data lines and shows that its buffer is full. When the strobe returns high the block can raise an interrupt. The CPU drains the byte with a read cycle, which takes the flags down again.

In the output direction a CPU write loads the output latch and pulls the active-low buffer-full line low. The peripheral takes the byte and answers with a low pulse on its acknowledge line. The falling edge of acknowledge releases buffer-full, and the rising edge raises the interrupt so the CPU can send the next byte.

The interrupt request has no enable register of its own. One enable flag belongs to each direction, and each is loaded by a bit set/reset command aimed at a particular Port C bit number. The strobe and acknowledge inputs are asynchronous. Both pass through two-stage synchronizers, and their edges are found in the system clock domain.

Top module: `hsp_port`

## Requirements
- R1: Reset (rst_n low) clears the input buffer-full flag, both interrupt-enable flags and the interrupt request, and sets the output buffer-full line high (inactive). With cfg_dir_in = 1, pc_out reads 8'h00, periph_oe is 0 and cpu_rdata is 8'h00. After reset, a strobe pulse sets buffer-full but raises no interrupt.
- R2: When cfg_dir_in = 1, a falling edge on pc_stb_n (Port C bit 4) captures periph_din and sets input buffer-full on pc_out[5]. The captured byte is returned on cpu_rdata. The update takes effect on the third rising clock edge after the input changes.
- R3: When cfg_dir_in = 1, a rising edge on pc_stb_n sets the interrupt request on pc_out[3]. This happens only if buffer-full is 1 and the input interrupt enable is set.
- R4: When cfg_dir_in = 1, the first cycle of a CPU read (cpu_rd going high) clears the interrupt request. The cycle in which cpu_rd returns low clears input buffer-full.
- R5: When cfg_dir_in = 0, a cpu_wr pulse loads cpu_wdata onto periph_dout, drives pc_out[7] (active-low buffer-full) low and clears the interrupt request. periph_oe is 1 in this direction.
- R6: When cfg_dir_in = 0, a falling edge on pc_ack_n (Port C bit 6) drives pc_out[7] high. A rising edge on pc_ack_n sets the interrupt request when the output interrupt enable is set.
- R7: A bit set/reset command (bsr_we with bsr_sel and bsr_val) loads bsr_val into the input interrupt enable when bsr_sel = 4, and into the output interrupt enable when bsr_sel = 6. Any other bsr_sel has no effect. pc_out[3] is the pending interrupt gated by the enable of the current direction, so it is never 1 while that enable is 0.
- R8: A cpu_wr in the input direction leaves periph_dout and pc_out unchanged. Strobe edges in the output direction leave pc_out unchanged. In the output direction cpu_rdata returns the output latch.
- R9: Any change of cfg_dir_in clears input buffer-full and the interrupt request, and sets the output buffer-full line high. The interrupt enables are kept. In the input direction pc_out[7] reads 0, and in the output direction pc_out[5] reads 0.
- R10: When edges coincide in one cycle, a strobe fall wins over a read end, so buffer-full stays 1 and holds the new byte. A CPU write wins over an acknowledge fall, so pc_out[7] stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_dir_in | input | 1 | Direction: 1 = peripheral to CPU, 0 = CPU to peripheral |
| cpu_wr | input | 1 | One-cycle CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read cycle, high for the length of the read |
| cpu_rdata | output | 8 | Input latch (input direction) or output latch (output direction) |
| bsr_we | input | 1 | One-cycle bit set/reset command strobe |
| bsr_sel | input | 3 | Port C bit number targeted by the command |
| bsr_val | input | 1 | Value written to the targeted bit |
| pc_stb_n | input | 1 | Port C bit 4: active-low strobe from the peripheral |
| pc_ack_n | input | 1 | Port C bit 6: active-low acknowledge from the peripheral |
| pc_out | output | 8 | Port C outputs: bit 3 interrupt, bit 5 input buffer-full, bit 7 active-low output buffer-full, other bits 0 |
| periph_din | input | 8 | Peripheral data toward the CPU |
| periph_dout | output | 8 | Output latch toward the peripheral |
| periph_oe | output | 1 | High when the block drives periph_dout |

## Verification
On every cycle, the in-line properties check several things: a strobe fall captures the byte and sets buffer-full, read start and read end clear their flags, a write pulls buffer-full low and beats an acknowledge fall, a direction change clears state, commands to other bit numbers leave the enables alone, and the interrupt line never rises without the matching enable. Other behaviour only the bench scenarios can show. This covers the three-edge synchronizer latency and the full byte flow through the ports in each direction. It also covers the masked interrupt coming back when its enable is set again, the ignored write and strobe in the wrong direction, and the two coincident-edge races, which are set up with exact cycle timing.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  // Port C bit positions of the handshake lines; the bit set/reset command decodes them
  localparam int unsigned PC_W      = 8;
  localparam int unsigned PC_INTR   = 3;
  localparam int unsigned PC_STB    = 4;
  localparam int unsigned PC_IBF    = 5;
  localparam int unsigned PC_ACK    = 6;
  localparam int unsigned PC_OBF    = 7;
  localparam int unsigned BSR_SEL_W = $clog2(PC_W);

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/hsp_sync_edge.sv
module hsp_sync_edge
  import hsp_pkg::*;
#(
  parameter int unsigned STAGES = 2,
  parameter bit          IDLE   = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  async_i,
  output edge_t edges_o
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q;
  logic              level;

  always_comb begin
    chain_d    = chain_q << 1;
    chain_d[0] = async_i;
  end

  assign level = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{IDLE}};
      prev_q  <= IDLE;
    end else begin
      chain_q <= chain_d;
      prev_q  <= level;
    end
  end

  assign edges_o.fall = prev_q & ~level;
  assign edges_o.rise = ~prev_q & level;
endmodule

// File: rtl/hsp_inte.sv
module hsp_inte
  import hsp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bsr_we,
  input  logic [BSR_SEL_W-1:0] bsr_sel,
  input  logic                 bsr_val,
  output logic                 inte_in_o,
  output logic                 inte_out_o
);
  logic hit_in, hit_out;

  assign hit_in  = bsr_we && (bsr_sel == BSR_SEL_W'(PC_STB));
  assign hit_out = bsr_we && (bsr_sel == BSR_SEL_W'(PC_ACK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inte_in_o <= 1'b0;
    end else if (hit_in) begin
      inte_in_o <= bsr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inte_out_o <= 1'b0;
    end else if (hit_out) begin
      inte_out_o <= bsr_val;
    end
  end

  // R7: commands on other Port C bits leave both enables untouched
  p_bsr_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bsr_we && bsr_sel != BSR_SEL_W'(PC_STB) && bsr_sel != BSR_SEL_W'(PC_ACK))
      |=> ($stable(inte_in_o) && $stable(inte_out_o)));
endmodule

// File: rtl/hsp_in_path.sv
module hsp_in_path
  import hsp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  edge_t         stb,
  input  logic          rd_start,
  input  logic          rd_end,
  input  logic          inte,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] data_o,
  output logic          ibf_o,
  output logic          irq_o
);
  logic ibf_d, irq_d;
  logic data_en;

  assign data_en = en & ~clr & stb.fall;

  always_comb begin
    ibf_d = ibf_o;
    irq_d = irq_o;
    if (clr) begin
      ibf_d = 1'b0;
      irq_d = 1'b0;
    end else if (en) begin
      if (rd_start) irq_d = 1'b0;
      if (rd_end)   ibf_d = 1'b0;
      if (stb.fall) ibf_d = 1'b1;
      if (stb.rise && ibf_d && inte) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
    end else if (data_en) begin
      data_o <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      ibf_o <= ibf_d;
      irq_o <= irq_d;
    end
  end

  p_stb_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && stb.fall) |=> (ibf_o && data_o == $past(din)));

  p_rd_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && rd_end && !stb.fall) |=> !ibf_o);

  p_rd_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && rd_start && !stb.rise) |=> !irq_o);

  p_dir_clear_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!ibf_o && !irq_o));
endmodule

// File: rtl/hsp_out_path.sv
module hsp_out_path
  import hsp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  edge_t         ack,
  input  logic          inte,
  output logic [DW-1:0] data_o,
  output logic          obf_n_o,
  output logic          irq_o
);
  logic obf_n_d, irq_d;
  logic data_en;

  assign data_en = en & ~clr & wr;

  always_comb begin
    obf_n_d = obf_n_o;
    irq_d   = irq_o;
    if (clr) begin
      obf_n_d = 1'b1;
      irq_d   = 1'b0;
    end else if (en) begin
      if (ack.fall)         obf_n_d = 1'b1;
      if (ack.rise && inte) irq_d   = 1'b1;
      if (wr) begin
        obf_n_d = 1'b0;
        irq_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
    end else if (data_en) begin
      data_o <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf_n_o <= 1'b1;
      irq_o   <= 1'b0;
    end else begin
      obf_n_o <= obf_n_d;
      irq_o   <= irq_d;
    end
  end

  p_wr_obf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && wr) |=> (!obf_n_o && !irq_o && data_o == $past(wdata)));

  p_ack_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && ack.fall && !wr) |=> obf_n_o);

  p_wr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && wr && ack.fall) |=> !obf_n_o);
endmodule

// File: rtl/hsp_port.sv
module hsp_port
  import hsp_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_dir_in,
  input  logic                 cpu_wr,
  input  logic [DW-1:0]        cpu_wdata,
  input  logic                 cpu_rd,
  output logic [DW-1:0]        cpu_rdata,
  input  logic                 bsr_we,
  input  logic [BSR_SEL_W-1:0] bsr_sel,
  input  logic                 bsr_val,
  input  logic                 pc_stb_n,
  input  logic                 pc_ack_n,
  output logic [PC_W-1:0]      pc_out,
  input  logic [DW-1:0]        periph_din,
  output logic [DW-1:0]        periph_dout,
  output logic                 periph_oe
);
  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rsync_q;
  logic                  rst_int_n;
  logic                  dir_q, rd_q;
  logic                  dir_chg, rd_start, rd_end;
  edge_t                 stb_e, ack_e;
  logic [DW-1:0]         in_data, out_data;
  logic                  ibf, in_irq, obf_n, out_irq;
  logic                  inte_in, inte_out, intr;
  logic [PC_W-1:0]       pc_c;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rsync_q[RST_STAGES-1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dir_q <= 1'b1;
      rd_q  <= 1'b0;
    end else begin
      dir_q <= cfg_dir_in;
      rd_q  <= cpu_rd;
    end
  end

  assign dir_chg  = dir_q ^ cfg_dir_in;
  assign rd_start = cpu_rd & ~rd_q;
  assign rd_end   = ~cpu_rd & rd_q;

  hsp_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_stb_sync (
    .clk(clk), .rst_n(rst_int_n), .async_i(pc_stb_n), .edges_o(stb_e));

  hsp_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_ack_sync (
    .clk(clk), .rst_n(rst_int_n), .async_i(pc_ack_n), .edges_o(ack_e));

  hsp_inte u_inte (
    .clk(clk), .rst_n(rst_int_n), .bsr_we(bsr_we), .bsr_sel(bsr_sel),
    .bsr_val(bsr_val), .inte_in_o(inte_in), .inte_out_o(inte_out));

  hsp_in_path #(.DW(DW)) u_in (
    .clk(clk), .rst_n(rst_int_n), .en(cfg_dir_in), .clr(dir_chg),
    .stb(stb_e), .rd_start(rd_start), .rd_end(rd_end), .inte(inte_in),
    .din(periph_din), .data_o(in_data), .ibf_o(ibf), .irq_o(in_irq));

  hsp_out_path #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_int_n), .en(~cfg_dir_in), .clr(dir_chg),
    .wr(cpu_wr), .wdata(cpu_wdata), .ack(ack_e), .inte(inte_out),
    .data_o(out_data), .obf_n_o(obf_n), .irq_o(out_irq));

  assign intr = cfg_dir_in ? (in_irq & inte_in) : (out_irq & inte_out);

  always_comb begin
    pc_c          = '0;
    pc_c[PC_INTR] = intr;
    if (cfg_dir_in) pc_c[PC_IBF] = ibf;
    else            pc_c[PC_OBF] = obf_n;
  end

  assign pc_out      = pc_c;
  assign cpu_rdata   = cfg_dir_in ? in_data : out_data;
  assign periph_dout = out_data;
  assign periph_oe   = ~cfg_dir_in;

  // R7: no request leaves the block while the current direction's enable is clear
  p_intr_gate_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    pc_out[PC_INTR] |-> (cfg_dir_in ? inte_in : inte_out));
endmodule

// File: tb/test_hsp_port.sv
`timescale 1ns/1ps
module test_hsp_port;
  localparam int OP_BSR = 0, OP_STBF = 1, OP_STBR = 2, OP_RDS = 3, OP_RDE = 4,
                 OP_WR = 5, OP_ACKF = 6, OP_ACKR = 7, OP_DIR = 8;
  localparam int NV = 23;
  // {req[3:0], op[3:0], data[7:0], exp_pc[7:0], exp_dat[7:0], chk_dat}
  localparam logic [32:0] VEC [NV] = '{
    {4'd7,  4'(OP_BSR),  8'h41, 8'h00, 8'h00, 1'b0}, // R7 input enable on
    {4'd2,  4'(OP_STBF), 8'hA5, 8'h20, 8'hA5, 1'b1}, // R2
    {4'd3,  4'(OP_STBR), 8'h00, 8'h28, 8'h00, 1'b0}, // R3
    {4'd4,  4'(OP_RDS),  8'h00, 8'h20, 8'hA5, 1'b1}, // R4
    {4'd4,  4'(OP_RDE),  8'h00, 8'h00, 8'h00, 1'b0}, // R4
    {4'd7,  4'(OP_BSR),  8'h40, 8'h00, 8'h00, 1'b0}, // R7 enable off
    {4'd2,  4'(OP_STBF), 8'h3C, 8'h20, 8'h3C, 1'b1}, // R2
    {4'd7,  4'(OP_STBR), 8'h00, 8'h20, 8'h00, 1'b0}, // R7 masked
    {4'd7,  4'(OP_BSR),  8'h41, 8'h20, 8'h00, 1'b0}, // R7
    {4'd4,  4'(OP_RDS),  8'h00, 8'h20, 8'h3C, 1'b1}, // R4
    {4'd4,  4'(OP_RDE),  8'h00, 8'h00, 8'h00, 1'b0}, // R4
    {4'd9,  4'(OP_DIR),  8'h00, 8'h80, 8'h00, 1'b0}, // R9
    {4'd7,  4'(OP_BSR),  8'h61, 8'h80, 8'h00, 1'b0}, // R7 output enable on
    {4'd5,  4'(OP_WR),   8'h5A, 8'h00, 8'h5A, 1'b1}, // R5
    {4'd6,  4'(OP_ACKF), 8'h00, 8'h80, 8'h00, 1'b0}, // R6
    {4'd6,  4'(OP_ACKR), 8'h00, 8'h88, 8'h00, 1'b0}, // R6
    {4'd5,  4'(OP_WR),   8'hC3, 8'h00, 8'hC3, 1'b1}, // R5
    {4'd6,  4'(OP_ACKF), 8'h00, 8'h80, 8'h00, 1'b0}, // R6
    {4'd6,  4'(OP_ACKR), 8'h00, 8'h88, 8'h00, 1'b0}, // R6
    {4'd7,  4'(OP_BSR),  8'h60, 8'h80, 8'h00, 1'b0}, // R7 masked
    {4'd7,  4'(OP_BSR),  8'h21, 8'h80, 8'h00, 1'b0}, // R7 other bit
    {4'd7,  4'(OP_BSR),  8'h61, 8'h88, 8'h00, 1'b0}, // R7 unmasked again
    {4'd9,  4'(OP_DIR),  8'h01, 8'h00, 8'h00, 1'b0}  // R9
  };

  logic       clk = 1'b0;
  logic       rst_n, cfg_dir_in, cpu_wr, cpu_rd, bsr_we, bsr_val;
  logic       pc_stb_n, pc_ack_n, periph_oe;
  logic [7:0] cpu_wdata, cpu_rdata, pc_out, periph_din, periph_dout;
  logic [2:0] bsr_sel;
  int         errors = 0;
  int         checks = 0;
  bit         done   = 1'b0;

  always #10 clk = ~clk;

  hsp_port i_hsp_port (
    .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .bsr_we(bsr_we), .bsr_sel(bsr_sel), .bsr_val(bsr_val),
    .pc_stb_n(pc_stb_n), .pc_ack_n(pc_ack_n), .pc_out(pc_out),
    .periph_din(periph_din), .periph_dout(periph_dout), .periph_oe(periph_oe));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_op(input int op, input logic [7:0] d);
    case (op)
      OP_BSR:  begin
                 bsr_we = 1'b1; bsr_sel = d[6:4]; bsr_val = d[0];
                 tick(1); bsr_we = 1'b0; tick(1);
               end
      OP_STBF: begin periph_din = d; pc_stb_n = 1'b0; tick(4); end
      OP_STBR: begin pc_stb_n = 1'b1; tick(4); end
      OP_RDS:  begin cpu_rd = 1'b1; tick(2); end
      OP_RDE:  begin cpu_rd = 1'b0; tick(2); end
      OP_WR:   begin
                 cpu_wdata = d; cpu_wr = 1'b1;
                 tick(1); cpu_wr = 1'b0; tick(1);
               end
      OP_ACKF: begin pc_ack_n = 1'b0; tick(4); end
      OP_ACKR: begin pc_ack_n = 1'b1; tick(4); end
      default: begin cfg_dir_in = d[0]; tick(2); end
    endcase
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_dir_in = 1'b1; cpu_wr = 1'b0; cpu_rd = 1'b0;
    bsr_we = 1'b0; bsr_sel = '0; bsr_val = 1'b0; pc_stb_n = 1'b1;
    pc_ack_n = 1'b1; cpu_wdata = '0; periph_din = '0;
    tick(3);
    // R1: reset state
    chk("R1 pc_out", pc_out, 8'h00);
    chk("R1 periph_oe", {7'd0, periph_oe}, 8'h00);
    chk("R1 cpu_rdata", cpu_rdata, 8'h00);
    rst_n = 1'b1;
    tick(4);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      string       tag;
      v   = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[32:29], i);
      run_op(int'(v[28:25]), v[24:17]);
      chk({tag, " pc_out"}, pc_out, v[16:9]);
      if (v[0]) begin
        if (int'(v[28:25]) == OP_WR) chk({tag, " periph_dout"}, periph_dout, v[8:1]);
        else                         chk({tag, " cpu_rdata"}, cpu_rdata, v[8:1]);
      end
    end

    // R8: write in the input direction is ignored
    run_op(OP_WR, 8'h77);
    chk("R8 write ignored dout", periph_dout, 8'hC3);
    chk("R8 write ignored pc_out", pc_out, 8'h00);
    chk("R8 periph_oe input", {7'd0, periph_oe}, 8'h00);

    // R8: strobe ignored in the output direction; rdata shows the output latch
    run_op(OP_DIR, 8'h00);
    run_op(OP_STBF, 8'h11);
    run_op(OP_STBR, 8'h00);
    chk("R8 strobe ignored pc_out", pc_out, 8'h80);
    chk("R8 rdata output latch", cpu_rdata, 8'hC3);
    chk("R5 periph_oe output", {7'd0, periph_oe}, 8'h01);
    run_op(OP_DIR, 8'h01);
    chk("R9 back to input", pc_out, 8'h00);

    // R10: strobe fall coincides with read end
    cpu_rd = 1'b1; tick(2);
    periph_din = 8'h96; pc_stb_n = 1'b0;
    tick(2);
    cpu_rd = 1'b0;
    tick(2);
    chk("R10 strobe beats read end", pc_out, 8'h20);
    chk("R10 new byte", cpu_rdata, 8'h96);
    run_op(OP_STBR, 8'h00);
    chk("R3 intr after race", pc_out, 8'h28);
    run_op(OP_RDS, 8'h00);
    run_op(OP_RDE, 8'h00);
    chk("R4 drained", pc_out, 8'h00);

    // R10: write coincides with acknowledge fall
    run_op(OP_DIR, 8'h00);
    pc_ack_n = 1'b0;
    tick(2);
    cpu_wdata = 8'hE7; cpu_wr = 1'b1;
    tick(1); cpu_wr = 1'b0;
    tick(1);
    chk("R10 write beats ack fall", pc_out, 8'h00);
    chk("R10 dout", periph_dout, 8'hE7);
    run_op(OP_ACKR, 8'h00);
    chk("R6 ack rise with obf low", pc_out, 8'h08);

    // R1: reset mid-run clears enables
    cfg_dir_in = 1'b1;
    rst_n = 1'b0;
    tick(2);
    chk("R1 in reset pc_out", pc_out, 8'h00);
    chk("R1 in reset periph_oe", {7'd0, periph_oe}, 8'h00);
    rst_n = 1'b1;
    tick(4);
    run_op(OP_STBF, 8'h42);
    run_op(OP_STBR, 8'h00);
    chk("R1 enable cleared by reset", pc_out, 8'h20);
    chk("R2 byte after reset", cpu_rdata, 8'h42);

    done = 1'b1;
    report();
    $finish;
  end
endmodule